// File: doc/BRIEF.md
# Run-Time Polynomial GF(2^8) Multiplier

This block multiplies two bytes as elements of a binary field GF(2^8) whose defining polynomial is not fixed in the logic but supplied on an input each cycle. The caller gives the low eight coefficients of the polynomial; the x^8 coefficient is always one and is not supplied. The polynomial should be irreducible for the result to be a true field product; the block does not check this.

Internally a first stage forms the 15-bit carry-less (XOR-accumulated) product of the two operands. A second stage folds that product down to eight bits: it walks from bit 14 down to bit 8, and wherever the current bit is set it XORs in the full polynomial (x^8 term included) shifted left by that bit's position minus eight. The folded byte is captured in an output register together with a valid flag, so a request presented with its valid bit is answered exactly one cycle later. Typical use is in table generators or data paths for ciphers whose field polynomial is a run-time choice.

Top module: `gf_polymul`

## Requirements
- R1: While rst_ni is low and on the first cycle after it rises, res_valid_o is 0 and res_o is 0x00.
- R2: res_valid_o is 1 in the cycle after a clock edge at which req_valid_i was 1, and 0 in the cycle after an edge at which req_valid_i was 0.
- R3: With poly_i = 0x1B (polynomial x^8+x^4+x^3+x+1), operands 0x57 and 0x83 give res_o = 0xC1.
- R4: Multiplying any operand by 0x01 gives that operand unchanged, for any poly_i.
- R5: Multiplying any operand by 0x00 gives 0x00, for any poly_i.
- R6: For any operands and poly_i, res_o equals the 15-bit carry-less product reduced modulo x^8 + poly_i, with bit k of poly_i the coefficient of x^k.
- R7: The product is commutative: swapping op_a_i and op_b_i does not change res_o.
- R8: At a clock edge where req_valid_i is 0, res_o keeps its previous value whatever the operand and polynomial inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Operands and polynomial are valid this cycle |
| op_a_i | input | 8 | First field operand |
| op_b_i | input | 8 | Second field operand |
| poly_i | input | 8 | Low eight coefficients of the reduction polynomial |
| res_valid_o | output | 1 | Result register holds a fresh product |
| res_o | output | 8 | Reduced product |

## Verification
The known vector 0x57 times 0x83 under 0x1B pins down the standard field and would expose a shift or bit-order slip in either stage. Identity and zero operands under several polynomials separate the product stage from the reduction stage, since neither case leaves any bit above 7. A sweep of operand pairs under the polynomials 0x1B, 0x1D, 0x2B and 0xFF exercises every fold layer and every coefficient gate against a bench-side reference, and swapped operands test symmetry. Operand changes with the valid bit low show that the result register does not reload.

// File: rtl/gfm_pkg.sv
package gfm_pkg;
  localparam int unsigned GF_W  = 8;
  localparam int unsigned GF_PW = 2 * GF_W - 1;
endpackage

// File: rtl/gfm_clmul.sv
module gfm_clmul #(
  parameter int unsigned W  = gfm_pkg::GF_W,
  localparam int unsigned PW = 2 * W - 1
) (
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  output logic [PW-1:0] clmul_o
);
  logic [PW-1:0] acc [W+1];
  assign acc[0] = '0;

  for (genvar j = 0; j < W; j++) begin : g_pp
    logic [PW-1:0] pp;
    assign pp       = ({{(W-1){1'b0}}, a_i} << j) & {PW{b_i[j]}};
    assign acc[j+1] = acc[j] ^ pp;
  end

  assign clmul_o = acc[W];

  always_comb begin
    if (b_i == W'(1))
      AST_UNIT_OPERAND: assert (clmul_o == {{(W-1){1'b0}}, a_i}); // R4
    if (a_i == '0 || b_i == '0)
      AST_ZERO_OPERAND: assert (clmul_o == '0); // R5
  end
endmodule

// File: rtl/gfm_reduce.sv
module gfm_reduce #(
  parameter int unsigned W  = gfm_pkg::GF_W,
  localparam int unsigned PW = 2 * W - 1,
  localparam int unsigned NL = W - 1
) (
  input  logic [PW-1:0] wide_i,
  input  logic [W-1:0]  poly_i,
  output logic [W-1:0]  red_o
);
  logic [PW-1:0] lvl [NL+1];
  logic [PW-1:0] poly_full;

  // x^8 term implied, padded to product width
  assign poly_full = {{(PW-W-1){1'b0}}, 1'b1, poly_i};
  assign lvl[0]    = wide_i;

  // one layer per high bit, top bit first
  for (genvar i = 0; i < NL; i++) begin : g_fold
    localparam int unsigned K = PW - 1 - i;
    logic [PW-1:0] term;
    assign term     = (poly_full << (K - W)) & {PW{lvl[i][K]}};
    assign lvl[i+1] = lvl[i] ^ term;
  end

  assign red_o = lvl[NL][W-1:0];

  always_comb begin
    AST_HIGH_CLEARED: assert (lvl[NL][PW-1:W] == '0); // R6
    if (wide_i[PW-1:W] == '0)
      AST_NO_FOLD_PASS: assert (red_o == wide_i[W-1:0]); // R6
  end
endmodule

// File: rtl/gf_polymul.sv
module gf_polymul #(
  parameter int unsigned W  = gfm_pkg::GF_W,
  localparam int unsigned PW = 2 * W - 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_valid_i,
  input  logic [W-1:0] op_a_i,
  input  logic [W-1:0] op_b_i,
  input  logic [W-1:0] poly_i,
  output logic         res_valid_o,
  output logic [W-1:0] res_o
);
  logic [PW-1:0] wide;
  logic [W-1:0]  red;
  logic          vld_q;
  logic [W-1:0]  res_q;

  gfm_clmul #(.W(W)) i_clmul (
    .a_i     (op_a_i),
    .b_i     (op_b_i),
    .clmul_o (wide)
  );

  gfm_reduce #(.W(W)) i_reduce (
    .wide_i (wide),
    .poly_i (poly_i),
    .red_o  (red)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= req_valid_i;
      if (req_valid_i) res_q <= red;
    end
  end

  assign res_valid_o = vld_q;
  assign res_o       = res_q;

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> res_valid_o); // R2
  AST_VALID_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !res_valid_o); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> $stable(res_o)); // R8
  AST_ZERO_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (op_a_i == '0 || op_b_i == '0)) |=> (res_o == '0)); // R5
endmodule

// File: tb/test_gf_polymul.sv
module test_gf_polymul;
  localparam int unsigned CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vld = 1'b0;
  logic [7:0] a = '0, b = '0, p = '0;
  logic       res_valid;
  logic [7:0] res;
  int         n_checks = 0;
  int         n_errors = 0;
  bit         done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  gf_polymul i_gf_polymul (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_valid_i (vld),
    .op_a_i      (a),
    .op_b_i      (b),
    .poly_i      (p),
    .res_valid_o (res_valid),
    .res_o       (res)
  );

  function automatic logic [7:0] ref_mul(input logic [7:0] x, input logic [7:0] y,
                                         input logic [7:0] f);
    logic [14:0] w = '0;
    for (int j = 0; j < 8; j++) if (y[j]) w = w ^ (15'(x) << j);
    for (int k = 14; k >= 8; k--) if (w[k]) w = w ^ (15'({1'b1, f}) << (k - 8));
    return w[7:0];
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // one request; returns the registered result sampled mid-cycle
  task automatic run_op(input logic [7:0] x, input logic [7:0] y, input logic [7:0] f,
                        output logic [7:0] r);
    @(negedge clk);
    a = x; b = y; p = f; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
    r = res;
  endtask

  task automatic t_reset();
    #(CLK_PERIOD * 2);
    check("R1 valid in reset", {7'd0, res_valid}, 8'h00);
    check("R1 result in reset", res, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", {7'd0, res_valid}, 8'h00);
    check("R1 result after reset", res, 8'h00);
  endtask

  task automatic t_known();
    logic [7:0] r;
    run_op(8'h57, 8'h83, 8'h1B, r);
    check("R3 57*83 mod 11B", r, 8'hC1);
  endtask

  task automatic t_latency();
    logic [7:0] r;
    run_op(8'h12, 8'h34, 8'h1B, r);
    check("R2 valid one cycle after request", {7'd0, res_valid}, 8'h01);
    @(negedge clk);
    check("R2 valid drops when idle", {7'd0, res_valid}, 8'h00);
  endtask

  task automatic t_identity();
    logic [7:0] r;
    logic [7:0] polys [4] = '{8'h1B, 8'h1D, 8'h2B, 8'hFF};
    foreach (polys[i]) begin
      run_op(8'hA5 + 8'(i * 37), 8'h01, polys[i], r);
      check("R4 x*1", r, 8'hA5 + 8'(i * 37));
      run_op(8'h01, 8'hE7 ^ 8'(i), polys[i], r);
      check("R4 1*x", r, 8'hE7 ^ 8'(i));
    end
  endtask

  task automatic t_zero();
    logic [7:0] r;
    run_op(8'hFF, 8'h00, 8'h1D, r);
    check("R5 x*0", r, 8'h00);
    run_op(8'h00, 8'h9C, 8'hFF, r);
    check("R5 0*x", r, 8'h00);
  endtask

  task automatic t_sweep();
    logic [7:0] r, r2;
    logic [7:0] polys [4] = '{8'h1B, 8'h1D, 8'h2B, 8'hFF};
    logic [15:0] lfsr = 16'hACE1;
    foreach (polys[i]) begin
      for (int n = 0; n < 24; n++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        run_op(lfsr[15:8], lfsr[7:0], polys[i], r);
        check("R6 reduced product", r, ref_mul(lfsr[15:8], lfsr[7:0], polys[i]));
        run_op(lfsr[7:0], lfsr[15:8], polys[i], r2);
        check("R7 swapped operands", r2, r);
      end
    end
    run_op(8'h80, 8'h80, 8'h1B, r);
    check("R6 top bit only", r, ref_mul(8'h80, 8'h80, 8'h1B));
    run_op(8'hFF, 8'hFF, 8'hFF, r);
    check("R6 all ones", r, ref_mul(8'hFF, 8'hFF, 8'hFF));
  endtask

  task automatic t_hold();
    logic [7:0] r;
    run_op(8'h57, 8'h13, 8'h1B, r);
    @(negedge clk);
    a = 8'hFF; b = 8'hFF; p = 8'h2B;
    @(negedge clk);
    check("R8 hold with valid low", res, r);
    a = 8'h00;
    @(negedge clk);
    check("R8 hold after second change", res, r);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_known();
    t_latency();
    t_identity();
    t_zero();
    t_sweep();
    t_hold();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule